// File: doc/BRIEF.md
# Pin Interrupt Sense Unit

This block watches the twenty input pins of one general-purpose I/O port and turns pin activity into interrupt requests. Each pin is configured on its own: it can be sensed by edge or by level, it can react to one polarity or, in edge mode, to both transitions, and it can be allowed or blocked from raising the shared interrupt. Pin inputs are first brought into the block clock domain by a two-flop synchronizer. A transition is found by comparing the synchronized value with its value one clock earlier.

Detected events land in a raw status vector. In edge mode a status bit is sticky until software clears it. In level mode the bit tracks the active level. A masked status vector, which is raw status gated by the per-pin enable, drives a single combined interrupt line. Software reaches the block through a simple register port with a write strobe, an address and write data. Read data is returned combinationally from the address.

Top module: `pin_irq_sense`

## Requirements
- R1: Register bits 19:0 belong to pins 0 to 19. Bits 31:20 of every register read as zero and ignore writes.
- R2: With the level-select bit (offset 0x0C, 1 = level) at 0 and the polarity bit (offset 0x14) at 0, a rising pin transition sets that pin's raw status bit (read at offset 0x1C) within three clock edges. A falling transition sets nothing.
- R3: In edge mode, polarity 1 selects falling transitions. A 1 in the dual-edge register (offset 0x10) makes both transitions set the raw bit, whatever the polarity.
- R4: In edge mode a raw bit remains set until a write to offset 0x1C with a 1 in that bit position. If a new edge and such a clear reach the same bit in the same clock, the bit stays set.
- R5: In level mode the raw bit follows the active level, which is high for polarity 0 and low for polarity 1. A clear write does not remove it while the level lasts. The dual-edge bit has no effect in this mode.
- R6: After reset the level-select, dual-edge, polarity, enable and raw status registers all read zero, and the interrupt output is low.
- R7: The enable register (offset 0x18, 1 = enabled) gates only the masked status (offset 0x20) and the interrupt. A disabled pin still records its events in raw status.
- R8: The interrupt output is high exactly when any masked status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 20 | Asynchronous pin levels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench aims a clear write at the exact clock in which a fresh edge lands on an already-set bit. A design that gives the clear priority loses that edge and reads zero. Level-mode pins get a clear write while their level is held, which exposes a design that makes level bits sticky or clearable. A level pin with its dual-edge bit set is raised and then dropped, so a design that latches edges in level mode keeps the bit when it should fall. A disabled pin is toggled to show that raw status records the event while the masked status and the interrupt stay quiet. A design that gates detection with the enable would lose the raw bit.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  // Register byte offsets; software depends on these values.
  localparam int unsigned OFF_LEVEL_SEL = 32'h0C;
  localparam int unsigned OFF_DUAL_EDGE = 32'h10;
  localparam int unsigned OFF_POLARITY  = 32'h14;
  localparam int unsigned OFF_ENABLE    = 32'h18;
  localparam int unsigned OFF_RAW_CLR   = 32'h1C;
  localparam int unsigned OFF_MASKED    = 32'h20;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;
  logic [WIDTH-1:0] meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = async_i;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
  parameter int WIDTH = 20
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] prev_i,
  input  logic [WIDTH-1:0] level_sel_i,
  input  logic [WIDTH-1:0] dual_i,
  input  logic [WIDTH-1:0] pol_i,
  output logic [WIDTH-1:0] edge_hit_o,
  output logic [WIDTH-1:0] level_act_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic rise, fall, pick;
    assign rise = cur_i[i] & ~prev_i[i];
    assign fall = ~cur_i[i] & prev_i[i];
    // dual-edge overrides polarity, edge mode only
    assign pick = dual_i[i] ? (rise | fall) : (pol_i[i] ? fall : rise);
    assign edge_hit_o[i]  = ~level_sel_i[i] & pick;
    assign level_act_o[i] = level_sel_i[i] & (pol_i[i] ? ~cur_i[i] : cur_i[i]);
  end
endmodule

// File: rtl/pin_irq_cfg.sv
module pin_irq_cfg
  import pin_irq_pkg::*;
#(
  parameter int WIDTH  = 20,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  level_sel_o,
  output logic [WIDTH-1:0]  dual_o,
  output logic [WIDTH-1:0]  pol_o,
  output logic [WIDTH-1:0]  en_o
);
  logic [WIDTH-1:0] lvl_q, dual_q, pol_q, en_q;
  logic [WIDTH-1:0] lvl_d, dual_d, pol_d, en_d;

  always_comb begin
    lvl_d  = lvl_q;
    dual_d = dual_q;
    pol_d  = pol_q;
    en_d   = en_q;
    if (wr_en) begin
      if (addr == ADDR_W'(OFF_LEVEL_SEL)) lvl_d  = wdata;
      if (addr == ADDR_W'(OFF_DUAL_EDGE)) dual_d = wdata;
      if (addr == ADDR_W'(OFF_POLARITY))  pol_d  = wdata;
      if (addr == ADDR_W'(OFF_ENABLE))    en_d   = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      dual_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
    end else begin
      lvl_q  <= lvl_d;
      dual_q <= dual_d;
      pol_q  <= pol_d;
      en_q   <= en_d;
    end
  end

  assign level_sel_o = lvl_q;
  assign dual_o      = dual_q;
  assign pol_o       = pol_q;
  assign en_o        = en_q;
endmodule

// File: rtl/pin_irq_status.sv
module pin_irq_status #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_sel_i,
  input  logic [WIDTH-1:0] edge_hit_i,
  input  logic [WIDTH-1:0] level_act_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] raw_o
);
  logic [WIDTH-1:0] raw_q, raw_d;

  // level pins track the level; edge pins hold, and a new edge beats a clear
  always_comb begin
    raw_d = (level_sel_i & level_act_i)
          | (~level_sel_i & ((raw_q & ~clr_i) | edge_hit_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/pin_irq_sense.sv
module pin_irq_sense
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 20,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_o
);
  localparam int PAD_W = DATA_W - NUM_PINS;

  logic [1:0] rst_pipe_q, rst_pipe_d;
  logic       rst_sync_n;

  always_comb rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [NUM_PINS-1:0] sync_q, prev_q;
  logic [NUM_PINS-1:0] lvl_q, dual_q, pol_q, en_q;
  logic [NUM_PINS-1:0] edge_hit, level_act, clr_bits, raw_q, masked;
  logic [NUM_PINS-1:0] wdata_pins;
  logic                unused_wdata_hi;

  assign wdata_pins      = bus_wdata[NUM_PINS-1:0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_PINS];

  pin_irq_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .async_i(pin_i),
    .sync_o(sync_q), .prev_o(prev_q)
  );

  pin_irq_cfg #(.WIDTH(NUM_PINS), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(bus_we), .addr(bus_addr),
    .wdata(wdata_pins), .level_sel_o(lvl_q), .dual_o(dual_q),
    .pol_o(pol_q), .en_o(en_q)
  );

  pin_irq_detect #(.WIDTH(NUM_PINS)) u_detect (
    .cur_i(sync_q), .prev_i(prev_q), .level_sel_i(lvl_q), .dual_i(dual_q),
    .pol_i(pol_q), .edge_hit_o(edge_hit), .level_act_o(level_act)
  );

  assign clr_bits = (bus_we && bus_addr == ADDR_W'(OFF_RAW_CLR)) ? wdata_pins : '0;

  pin_irq_status #(.WIDTH(NUM_PINS)) u_status (
    .clk(clk), .rst_n(rst_sync_n), .level_sel_i(lvl_q), .edge_hit_i(edge_hit),
    .level_act_i(level_act), .clr_i(clr_bits), .raw_o(raw_q)
  );

  assign masked = raw_q & en_q;
  assign irq_o  = |masked;

  always_comb begin
    logic [NUM_PINS-1:0] sel;
    sel = '0;
    if      (bus_addr == ADDR_W'(OFF_LEVEL_SEL)) sel = lvl_q;
    else if (bus_addr == ADDR_W'(OFF_DUAL_EDGE)) sel = dual_q;
    else if (bus_addr == ADDR_W'(OFF_POLARITY))  sel = pol_q;
    else if (bus_addr == ADDR_W'(OFF_ENABLE))    sel = en_q;
    else if (bus_addr == ADDR_W'(OFF_RAW_CLR))   sel = raw_q;
    else if (bus_addr == ADDR_W'(OFF_MASKED))    sel = masked;
    bus_rdata = {{PAD_W{1'b0}}, sel};
  end
endmodule

// File: rtl/pin_irq_sense_chk.sv
module pin_irq_sense_chk #(
  parameter int NUM_PINS = 20,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic [NUM_PINS-1:0] sync_q,
  input logic [NUM_PINS-1:0] prev_q,
  input logic [NUM_PINS-1:0] lvl_q,
  input logic [NUM_PINS-1:0] pol_q,
  input logic [NUM_PINS-1:0] en_q,
  input logic [NUM_PINS-1:0] clr_bits,
  input logic [NUM_PINS-1:0] raw_q,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                irq_o
);
  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rdata[DATA_W-1:NUM_PINS] == '0);

  // no edge-mode bit may appear without a change on its synchronized pin
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(lvl_q) & ~($past(sync_q) ^ $past(prev_q))) == '0));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (($past(raw_q) & ~$past(lvl_q) & ~$past(clr_bits) & ~raw_q) == '0));

  assert_level_track_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (((raw_q ^ ($past(sync_q) ^ $past(pol_q))) & $past(lvl_q)) == '0));

  assert_irq_any_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o == ((raw_q & en_q) != '0));
endmodule

bind pin_irq_sense pin_irq_sense_chk #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .sync_q(sync_q), .prev_q(prev_q),
  .lvl_q(lvl_q), .pol_q(pol_q), .en_q(en_q), .clr_bits(clr_bits),
  .raw_q(raw_q), .bus_rdata(bus_rdata), .irq_o(irq_o)
);

// File: tb/pin_irq_sense_bench.sv
`timescale 1ns/1ps
module pin_irq_sense_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] pins;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] data;
    logic        irq;
    string       tag;
  } item_t;
  item_t exp_q[$];
  event  mon_ev;

  always #2 clk = ~clk;

  pin_irq_sense u_pin_irq_sense (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // monitor: pops expected items and compares them with the port values
  initial begin
    forever begin
      @(mon_ev);
      #1;
      while (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (bus_rdata !== it.data || irq_o !== it.irq) begin
          errors++;
          $display("FAIL %s addr=%02h: rdata=%08h irq=%0b expected rdata=%08h irq=%0b",
                   it.tag, it.addr, bus_rdata, irq_o, it.data, it.irq);
        end
      end
    end
  end

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] d, input logic irq, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.addr = a; it.data = d; it.irq = irq; it.tag = tag;
    exp_q.push_back(it);
    -> mon_ev;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pins = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    settle(4);
    rst_n = 1'b1;
    settle(3);

    // R6: reset state
    expect_rd(8'h0C, 32'h0, 1'b0, "R6 level-select");
    expect_rd(8'h10, 32'h0, 1'b0, "R6 dual-edge");
    expect_rd(8'h14, 32'h0, 1'b0, "R6 polarity");
    expect_rd(8'h18, 32'h0, 1'b0, "R6 enable");
    expect_rd(8'h1C, 32'h0, 1'b0, "R6 raw");

    // R1: upper bits dropped
    wr(8'h18, 32'hFFFF_FFFF);
    expect_rd(8'h18, 32'h000F_FFFF, 1'b0, "R1 reserved bits");
    wr(8'h18, 32'h000F_FFBF);   // pin 6 disabled

    // R2: rising edge default
    @(negedge clk); pins[0] = 1'b1; settle(4);
    expect_rd(8'h1C, 32'h1, 1'b1, "R2 rising sets raw");
    expect_rd(8'h20, 32'h1, 1'b1, "R8 masked and irq");
    @(negedge clk); pins[0] = 1'b0; settle(4);
    expect_rd(8'h1C, 32'h1, 1'b1, "R2 falling ignored, bit sticky");
    wr(8'h1C, 32'h1);
    expect_rd(8'h1C, 32'h0, 1'b0, "R4 clear write");

    // R3: falling polarity
    wr(8'h14, 32'h2);
    @(negedge clk); pins[1] = 1'b1; settle(4);
    expect_rd(8'h1C, 32'h0, 1'b0, "R3 rise ignored at polarity 1");
    @(negedge clk); pins[1] = 1'b0; settle(4);
    expect_rd(8'h1C, 32'h2, 1'b1, "R3 falling sets raw");
    wr(8'h1C, 32'h2);
    expect_rd(8'h1C, 32'h0, 1'b0, "R4 clear falling bit");

    // R3: dual edge
    wr(8'h10, 32'h4);
    @(negedge clk); pins[2] = 1'b1; settle(4);
    expect_rd(8'h1C, 32'h4, 1'b1, "R3 dual edge rise");
    wr(8'h1C, 32'h4);
    expect_rd(8'h1C, 32'h0, 1'b0, "R4 clear dual bit");
    @(negedge clk); pins[2] = 1'b0; settle(4);
    expect_rd(8'h1C, 32'h4, 1'b1, "R3 dual edge fall");
    wr(8'h1C, 32'h4);

    // R5: level mode, pin3 high-active, pin4 low-active, pin5 high-active with dual set
    wr(8'h14, 32'h12);
    wr(8'h10, 32'h24);
    wr(8'h0C, 32'h38);
    settle(2);
    expect_rd(8'h1C, 32'h10, 1'b1, "R5 low level active");
    @(negedge clk); pins[3] = 1'b1; settle(4);
    expect_rd(8'h1C, 32'h18, 1'b1, "R5 high level active");
    wr(8'h1C, 32'h18);
    expect_rd(8'h1C, 32'h18, 1'b1, "R5 clear blocked while level held");
    @(negedge clk); pins[3] = 1'b0; settle(4);
    expect_rd(8'h1C, 32'h10, 1'b1, "R5 bit follows level down");
    @(negedge clk); pins[5] = 1'b1; settle(4);
    expect_rd(8'h1C, 32'h30, 1'b1, "R5 dual bit, level high");
    @(negedge clk); pins[5] = 1'b0; settle(4);
    expect_rd(8'h1C, 32'h10, 1'b1, "R5 dual bit ignored in level mode");
    @(negedge clk); pins[4] = 1'b1; settle(4);
    expect_rd(8'h1C, 32'h0, 1'b0, "R5 low-active pin released");

    // R7: disabled pin records raw but no interrupt
    @(negedge clk); pins[6] = 1'b1; settle(4);
    expect_rd(8'h1C, 32'h40, 1'b0, "R7 raw set while disabled");
    expect_rd(8'h20, 32'h0, 1'b0, "R7 masked zero while disabled");
    wr(8'h1C, 32'h40);

    // R4: edge and clear in the same clock
    @(negedge clk); pins[7] = 1'b1; settle(4);
    expect_rd(8'h1C, 32'h80, 1'b1, "R2 pin7 rise");
    @(negedge clk); pins[7] = 1'b0; settle(4);
    @(negedge clk); pins[7] = 1'b1;
    settle(2);
    bus_we = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'h80;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    expect_rd(8'h1C, 32'h80, 1'b1, "R4 edge wins over clear");
    wr(8'h1C, 32'h80);
    expect_rd(8'h1C, 32'h0, 1'b0, "R4 later clear");
    expect_rd(8'h20, 32'h0, 1'b0, "R8 irq low with no masked bit");

    settle(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule